// File: doc/BRIEF.md
# Single-Clock FIFO with Post-Reset Write Hold-off

This block is a first-in first-out buffer in which both the producer and the consumer run on the same clock. It has a write enable with write data, a read enable with registered read data, and full and empty status flags. By default it holds 16 words of 4 bits. The producer watches `full` and the consumer watches `empty`.

The reset is asynchronous. While reset is held, and for a fixed number of clock edges after it is released, the FIFO takes no transfers. During that time it holds its flags in a hold-off pattern: `empty` is high, and `full` takes a level chosen by a parameter. With the default setting `full` is high, so upstream logic waits until the buffer is ready. With the other setting `full` stays low. Once the settling window has passed, the flags follow the occupancy, and `full` and `empty` are never both high.

The control path is a four-state machine:
- SETTLE is the reset and settling state.
- EMPTY means no words are stored.
- PARTIAL means between one and DEPTH-1 words are stored.
- FULL means DEPTH words are stored.

The transitions are:
- The reset entry puts the machine in SETTLE, whatever state it was in.
- The settle-done transition goes from SETTLE to EMPTY after HOLD_CYCLES rising edges.
- The first-write transition goes from EMPTY to PARTIAL.
- The fill transition goes from PARTIAL to FULL when the count reaches DEPTH.
- The drain transition goes from PARTIAL to EMPTY when the count reaches zero.
- The unfill transition goes from FULL to PARTIAL on a read.
- The stay transition keeps the same state when the count class does not change.

Top module: `cc_fifo_holdoff`

## Requirements
- R1: The FIFO uses one clock for both writing and reading. Asserting `rst_n` low clears it at once, without waiting for a clock edge. After the settling window it reports empty, and `rd_data` reads 0.
- R2: While `rst_n` is low, `empty` is 1 and `full` equals the FULL_IN_RESET parameter (default 1). Write and read enables have no effect.
- R3: After `rst_n` rises, `empty` stays 1 and `full` stays at FULL_IN_RESET through HOLD_CYCLES rising edges (default 2). The flags take their occupancy-based values after that last edge.
- R4: Write and read enables asserted during the settling window are ignored. When the window ends the FIFO is empty, with `full` at 0 and `empty` at 1.
- R5: Outside reset and the settling window, `full` and `empty` are never 1 at the same time.
- R6: Words are read out in the order they were written. `rd_data` changes only on the rising edge at which a read is accepted, and it shows the head word right after that edge.
- R7: `full` rises once DEPTH words are stored. A write while full is dropped and does not change the stored words.
- R8: A read while empty leaves `rd_data` unchanged and does not advance the read position.
- R9: A write and a read accepted on the same edge, when the FIFO is neither full nor empty, leave the occupancy unchanged. When full, a simultaneous read and write does only the read.
- R10: With FULL_IN_RESET set to 0, `full` stays 0 during reset and the settling window, while `empty` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both sides |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered head word, updated on an accepted read |
| full | output | 1 | No room left, or hold-off level during settling |
| empty | output | 1 | Nothing stored, or held high during settling |

## Verification
The bench drives both enables high across reset and the settling window. A design that opened the window one edge early, or that let a request through during settling, would show a non-empty FIFO or cleared flags too soon. It also writes into a full FIFO and reads from an empty one. A design that wrapped a pointer would then return a dropped word, or replay stale data, in the drain that follows. Simultaneous read and write are exercised both in the middle of the buffer and at full. An occupancy counter that moved on a balanced transfer shows up as a wrong number of words before `empty` returns. A second instance built with the low reset level for `full` confirms that the parameter changes only that flag.

// File: rtl/cchf_pkg.sv
package cchf_pkg;

    typedef enum logic [1:0] {
        ST_SETTLE  = 2'd0,
        ST_EMPTY   = 2'd1,
        ST_PARTIAL = 2'd2,
        ST_FULL    = 2'd3
    } fifo_state_t;

endpackage

// File: rtl/cchf_ptr.sv
module cchf_ptr #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [AW-1:0] ptr
);

    logic [AW-1:0] ptr_n;

    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            always_comb ptr_n = ptr + AW'(1);
        end else begin : g_wrap
            always_comb ptr_n = (ptr == AW'(DEPTH - 1)) ? '0 : ptr + AW'(1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   ptr <= '0;
        else if (adv) ptr <= ptr_n;
    end

endmodule

// File: rtl/cchf_mem.sv
module cchf_mem #(
    parameter int DATA_W = 4,
    parameter int DEPTH  = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= cells[raddr];
    end

endmodule

// File: rtl/cchf_ctrl.sv
module cchf_ctrl
    import cchf_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int HOLD_CYCLES   = 2,
    parameter bit FULL_IN_RESET = 1'b1,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int HC_W  = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES + 1) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic rd_en,
    output logic wr_ok,
    output logic rd_ok,
    output logic full,
    output logic empty
);

    fifo_state_t      state, state_n;
    logic [HC_W-1:0]  hold_cnt, hold_cnt_n;
    logic [CNT_W-1:0] count, count_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_SETTLE;
            hold_cnt <= '0;
            count    <= '0;
        end else begin
            state    <= state_n;
            hold_cnt <= hold_cnt_n;
            count    <= count_n;
        end
    end

    // occupancy update from accepted transfers
    always_comb begin
        unique case ({wr_ok, rd_ok})
            2'b10:   count_n = count + CNT_W'(1);
            2'b01:   count_n = count - CNT_W'(1);
            default: count_n = count;
        endcase
    end

    // next-state logic
    always_comb begin
        state_n    = state;
        hold_cnt_n = hold_cnt;
        unique case (state)
            ST_SETTLE: begin
                if (hold_cnt == HC_W'(HOLD_CYCLES - 1)) state_n = ST_EMPTY;
                else                                   hold_cnt_n = hold_cnt + HC_W'(1);
            end
            ST_EMPTY, ST_PARTIAL, ST_FULL: begin
                if (count_n == '0)                     state_n = ST_EMPTY;
                else if (count_n == CNT_W'(DEPTH))     state_n = ST_FULL;
                else                                   state_n = ST_PARTIAL;
            end
            default: state_n = ST_SETTLE;
        endcase
    end

    // outputs from state
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        wr_ok = 1'b0;
        rd_ok = 1'b0;
        unique case (state)
            ST_SETTLE: begin
                full  = FULL_IN_RESET;
                empty = 1'b1;
            end
            ST_EMPTY: begin
                empty = 1'b1;
                wr_ok = wr_en;
            end
            ST_PARTIAL: begin
                wr_ok = wr_en;
                rd_ok = rd_en;
            end
            ST_FULL: begin
                full  = 1'b1;
                rd_ok = rd_en;
            end
            default: begin
                full  = FULL_IN_RESET;
                empty = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cc_fifo_holdoff.sv
module cc_fifo_holdoff #(
    parameter int DATA_W        = 4,
    parameter int DEPTH         = 16,
    parameter int HOLD_CYCLES   = 2,
    parameter bit FULL_IN_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic          wr_ok, rd_ok;
    logic [AW-1:0] wr_ptr, rd_ptr;

    cchf_ctrl #(
        .DEPTH        (DEPTH),
        .HOLD_CYCLES  (HOLD_CYCLES),
        .FULL_IN_RESET(FULL_IN_RESET)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .wr_ok(wr_ok),
        .rd_ok(rd_ok),
        .full (full),
        .empty(empty)
    );

    cchf_ptr #(.DEPTH(DEPTH)) u_wptr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (wr_ok),
        .ptr  (wr_ptr)
    );

    cchf_ptr #(.DEPTH(DEPTH)) u_rptr (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (rd_ok),
        .ptr  (rd_ptr)
    );

    cchf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_ok),
        .waddr(wr_ptr),
        .wdata(wr_data),
        .re   (rd_ok),
        .raddr(rd_ptr),
        .rdata(rd_data)
    );

endmodule

// File: rtl/cc_fifo_holdoff_chk.sv
module cc_fifo_holdoff_chk #(
    parameter int DATA_W        = 4,
    parameter int HOLD_CYCLES   = 2,
    parameter bit FULL_IN_RESET = 1'b1,
    localparam int SW = $clog2(HOLD_CYCLES + 1) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              full,
    input logic              empty
);

    logic [SW-1:0] since;
    logic          settled;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         since <= '0;
        else if (since != SW'(HOLD_CYCLES)) since <= since + SW'(1);
    end

    assign settled = (since == SW'(HOLD_CYCLES));

    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !settled |-> (empty && (full == FULL_IN_RESET)));                  // R3
    AST_OPEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled) |-> (empty && !full));                              // R4
    AST_NO_FULL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        settled |-> !(full && empty));                                     // R5
    AST_RD_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !rd_en) |=> $stable(rd_data));                         // R6
    AST_FULL_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && full && wr_en && !rd_en) |=> full);                    // R7
    AST_EMPTY_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> $stable(rd_data));                  // R8

endmodule

bind cc_fifo_holdoff cc_fifo_holdoff_chk #(
    .DATA_W       (DATA_W),
    .HOLD_CYCLES  (HOLD_CYCLES),
    .FULL_IN_RESET(FULL_IN_RESET)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .rd_data(rd_data),
    .full   (full),
    .empty  (empty)
);

// File: tb/tb_cc_fifo_holdoff.sv
module tb_cc_fifo_holdoff;

    localparam int DW    = 4;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data, rd_data_lo;
    logic          full, empty, full_lo, empty_lo;

    int errors = 0;
    int checks = 0;
    logic [DW-1:0] model [$];

    always #5 clk = ~clk;

    cc_fifo_holdoff #(.DATA_W(DW), .DEPTH(DEPTH), .HOLD_CYCLES(2), .FULL_IN_RESET(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .full(full), .empty(empty)
    );

    cc_fifo_holdoff #(.DATA_W(DW), .DEPTH(DEPTH), .HOLD_CYCLES(2), .FULL_IN_RESET(1'b0)) dut_lo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data_lo), .full(full_lo), .empty(empty_lo)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
        if (model.size() < DEPTH) model.push_back(d);
    endtask

    task automatic pop(input string req);
        logic [DW-1:0] exp;
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
        exp = model.pop_front();
        check(req, "read word", int'(rd_data), int'(exp));
    endtask

    // R1 R2 R3 R4 R10: reset and settling with both enables held high
    task automatic t_reset();
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 4'hA;
        #2 rst_n = 1'b0;
        #1;
        check("R2", "full in reset", int'(full), 1);
        check("R2", "empty in reset", int'(empty), 1);
        check("R10", "low-variant full in reset", int'(full_lo), 0);
        check("R1", "rd_data cleared", int'(rd_data), 0);
        repeat (3) step();
        check("R2", "full held in reset", int'(full), 1);
        rst_n = 1'b1;
        step();
        check("R3", "full after edge 1", int'(full), 1);
        check("R3", "empty after edge 1", int'(empty), 1);
        check("R10", "low-variant full in window", int'(full_lo), 0);
        check("R10", "low-variant empty in window", int'(empty_lo), 1);
        wr_en = 1'b0; rd_en = 1'b0;
        step();
        check("R3", "full after window", int'(full), 0);
        check("R4", "empty after window", int'(empty), 1);
        check("R1", "rd_data after window", int'(rd_data), 0);
        model.delete();
    endtask

    // R6: order of several words
    task automatic t_order();
        for (int i = 0; i < 5; i++) push(DW'(i * 3 + 1));
        check("R5", "partial not empty", int'(empty), 0);
        check("R5", "partial not full", int'(full), 0);
        for (int i = 0; i < 5; i++) pop("R6");
        check("R6", "empty after drain", int'(empty), 1);
    endtask

    // R8: read while empty
    task automatic t_empty_read();
        push(4'h7);
        pop("R8");
        rd_en = 1'b1;
        repeat (2) step();
        rd_en = 1'b0;
        check("R8", "rd_data held on empty read", int'(rd_data), 7);
        push(4'h3);
        pop("R8");
        check("R8", "empty after single", int'(empty), 1);
    endtask

    // R7 R9: fill, overflow drop, simultaneous op at full, drain
    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) push(DW'(i ^ 5));
        check("R7", "full after DEPTH writes", int'(full), 1);
        check("R5", "not empty when full", int'(empty), 0);
        push(4'hF);
        check("R7", "full after dropped write", int'(full), 1);
        wr_en = 1'b1; rd_en = 1'b1; wr_data = 4'hE;
        step();
        wr_en = 1'b0; rd_en = 1'b0;
        check("R9", "read at full", int'(rd_data), int'(model.pop_front()));
        check("R9", "write dropped at full", int'(full), 0);
        for (int i = 0; i < DEPTH - 1; i++) pop("R7");
        check("R7", "empty after drain", int'(empty), 1);
    endtask

    // R9: balanced transfers in the middle
    task automatic t_simul();
        push(4'h1); push(4'h2); push(4'h3);
        for (int k = 0; k < 4; k++) begin
            logic [DW-1:0] exp;
            exp = model.pop_front();
            wr_en = 1'b1; rd_en = 1'b1; wr_data = DW'(k + 9);
            step();
            wr_en = 1'b0; rd_en = 1'b0;
            model.push_back(DW'(k + 9));
            check("R9", "simultaneous read word", int'(rd_data), int'(exp));
        end
        for (int i = 0; i < 2; i++) pop("R9");
        check("R9", "one left", int'(empty), 0);
        pop("R9");
        check("R9", "empty after three", int'(empty), 1);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_empty_read();
        t_full();
        t_simul();
        push(4'h6); push(4'h8);
        t_reset();
        check("R1", "reset clears stored words", int'(empty), 1);
        t_order();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule